// File: doc/BRIEF.md
# No-Turnaround Synchronous Burst SRAM

A clocked memory model with a pipelined, no-turnaround interface. It is meant as a target for self-checking benches or as an on-chip memory model. At each rising clock edge where the clock enable is active, the block decodes three chip selects, a burst/load strobe, a read/write strobe and one active-low write strobe per byte lane. From these it picks one of four actions: deselect, start a read at the supplied address, start a write at the supplied address, or continue the current burst from an internal counter.

Reads and writes share the same two-edge latency. A read returns its word two enabled edges after the command. A write takes its data from the bus at the second enabled edge after the command. Because both use the same latency, commands can alternate between read and write on every cycle with no idle slot. When the clock enable is inactive, every register in the block holds, so the whole pipeline freezes. The output enable only controls whether the data bus is driven.

Top module: `zbt_sram`

## Requirements
- R1: A synchronous reset clears every pending command, drops `rd_valid` and `dq_oe`, drives `dq_out` to zero, and leaves the burst direction at "none". Burst cycles issued right after reset therefore return no data.
- R2: A load cycle (`burst_nload`=0) on which the chip is not selected starts no operation. The chip is selected only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. Such a cycle produces no read two enabled edges later and writes nothing to memory.
- R3: A selected load cycle with `rd_nwr`=1 reads the word at `addr`. The word appears on `dq_out`, with `rd_valid`=1, after the second enabled edge that follows the command edge.
- R4: A selected load cycle with `rd_nwr`=0 writes to `addr` the value on `dq_in` at the second enabled edge after the command edge. Write cycles never raise `rd_valid`.
- R5: The write strobes are taken with the command and are active low. `lane_we_n[0]` gates bits 8:0 and `lane_we_n[1]` gates bits 17:9. A lane whose strobe is high keeps its old contents.
- R6: A cycle with `burst_nload`=1 ignores `addr` and the chip selects. It uses the loaded address with its two low bits advanced by one from the previous access, and it repeats the direction of the last load.
- R7: Burst cycles that follow a deselecting load stay deselected and produce no read data.
- R8: While `clk_en_n`=1, edges are ignored. Commands are not taken, the burst counter and pipeline hold, and `rd_valid` and `dq_out` stay unchanged.
- R9: `drv_en_n`=1 forces `dq_oe`=0 and `dq_out`=0. It does not change `rd_valid`, memory contents, or which operation is performed.
- R10: Reads and writes may alternate on consecutive enabled cycles. A read issued right after a write to the same address returns the newly written lanes merged with the old contents of the masked lanes.
- R11: The burst counter wraps within the aligned group of four words: loading low bits 2 yields 3, 0, 1, 2, … A new load restarts the sequence from the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; high freezes all state |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| burst_nload | input | 1 | 0 = load from `addr`, 1 = continue burst |
| rd_nwr | input | 1 | 1 = read, 0 = write (load cycles) |
| lane_we_n | input | LANES | Per-lane write strobes, active low |
| drv_en_n | input | 1 | Output drive enable, active low |
| addr | input | ADDR_W | Word address for load cycles |
| dq_in | input | LANE_W*LANES | Write data bus |
| dq_out | output | LANE_W*LANES | Read data bus, zero when not driven |
| dq_oe | output | 1 | High while `dq_out` carries driven read data |
| rd_valid | output | 1 | Read data of a completed read is present |

## Verification
The hardest situation to create from the ports is a clock-enable stall that lands inside a read burst, at a moment when one command is still in flight and another result is already on the bus. The stalled edges carry a conflicting write command, and the bench later reads that address back to prove the write was ignored. A second hard case is a masked write followed directly by a read of the same word. Every one of the four strobe patterns is swept over several addresses so that each merge of old and new lanes is observed.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

   // Operation carried down the pipeline; OP_NONE must stay the all-zero code
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;

endpackage

// File: rtl/zbt_ctrl.sv
// Command decoder and burst address generator
module zbt_ctrl
   import zbt_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int LANES      = 2,
   parameter int BURST_BITS = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              sel0_n,
   input  logic              sel1,
   input  logic              sel2_n,
   input  logic              burst_nload,
   input  logic              rd_nwr,
   input  logic [LANES-1:0]  lane_we_n,
   input  logic [ADDR_W-1:0] addr,
   output op_e               cmd_op,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [LANES-1:0]  cmd_be
);

   localparam int BB = BURST_BITS;

   op_e               last_op;
   logic [ADDR_W-1:0] base_q;
   logic [BB-1:0]     cnt_q;
   logic [BB-1:0]     cnt_nx;
   logic              chip_sel;
   logic              primed;

   assign chip_sel = ~sel0_n & sel1 & ~sel2_n;
   assign cnt_nx   = cnt_q + 1'b1;

   always_comb begin
      cmd_be = ~lane_we_n;
      if (!burst_nload) begin
         cmd_addr = addr;
         if (chip_sel) cmd_op = rd_nwr ? OP_READ : OP_WRITE;
         else          cmd_op = OP_NONE;
      end else begin
         cmd_addr = {base_q[ADDR_W-1:BB], base_q[BB-1:0] + cnt_nx};
         cmd_op   = last_op;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         last_op <= OP_NONE;
         base_q  <= '0;
         cnt_q   <= '0;
         primed  <= 1'b0;
      end else begin
         primed <= 1'b1;
         if (en) begin
            if (!burst_nload) begin
               last_op <= cmd_op;
               base_q  <= addr;
               cnt_q   <= '0;
            end else begin
               cnt_q <= cnt_nx;
            end
         end
      end
   end

   // R6: consecutive burst accesses step the low address bits by one
   p_burst_step_r6 : assert property (@(posedge clk) disable iff (rst)
      (primed && en && burst_nload && $past(en && burst_nload))
      |-> ((cmd_addr[BB-1:0] - $past(cmd_addr[BB-1:0])) == BB'(1)));

   // R6: the first burst after a load stays in the loaded group
   p_burst_base_r6 : assert property (@(posedge clk) disable iff (rst)
      (primed && en && burst_nload && $past(en && !burst_nload))
      |-> (cmd_addr[ADDR_W-1:BB] == $past(addr[ADDR_W-1:BB])));

endmodule

// File: rtl/zbt_pipe.sv
// Enable-gated delay line for in-flight commands
module zbt_pipe #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 1) begin : g_bad_depth
      $error("zbt_pipe: STAGES must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else if (en) begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/zbt_store.sv
// Lane-split storage array with registered read port
module zbt_store
   import zbt_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int LANE_W = 9,
   parameter int LANES  = 2
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      en,
   input  op_e                       op,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [LANES-1:0]          be,
   input  logic [LANE_W*LANES-1:0]   wdata,
   output logic [LANE_W*LANES-1:0]   rdata,
   output logic                      rvalid
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [LANE_W*LANES-1:0] rd_word;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] bank [DEPTH];

      always_ff @(posedge clk) begin
         if (en && op == OP_WRITE && be[l])
            bank[addr] <= wdata[l*LANE_W +: LANE_W];
      end

      assign rd_word[l*LANE_W +: LANE_W] = bank[addr];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rvalid <= 1'b0;
         rdata  <= '0;
      end else if (en) begin
         rvalid <= (op == OP_READ);
         if (op == OP_READ) rdata <= rd_word;
      end
   end

endmodule

// File: rtl/zbt_sram.sv
// No-turnaround pipelined burst SRAM, top level
module zbt_sram
   import zbt_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int LANE_W      = 9,
   parameter int LANES       = 2,
   parameter int PIPE_STAGES = 2,
   parameter int BURST_BITS  = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    clk_en_n,
   input  logic                    sel0_n,
   input  logic                    sel1,
   input  logic                    sel2_n,
   input  logic                    burst_nload,
   input  logic                    rd_nwr,
   input  logic [LANES-1:0]        lane_we_n,
   input  logic                    drv_en_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANE_W*LANES-1:0] dq_in,
   output logic [LANE_W*LANES-1:0] dq_out,
   output logic                    dq_oe,
   output logic                    rd_valid
);

   localparam int DW    = LANE_W * LANES;
   localparam int CMD_W = ADDR_W + LANES + 2;

   if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
      $error("zbt_sram: LANES and LANE_W must be positive");
   end
   if (BURST_BITS < 1 || BURST_BITS >= ADDR_W) begin : g_bad_burst
      $error("zbt_sram: BURST_BITS must lie in 1..ADDR_W-1");
   end
   if (PIPE_STAGES < 1) begin : g_bad_pipe
      $error("zbt_sram: PIPE_STAGES must be at least 1");
   end

   logic              en;
   op_e               c_op;
   op_e               x_op;
   logic [ADDR_W-1:0] c_addr;
   logic [ADDR_W-1:0] x_addr;
   logic [LANES-1:0]  c_be;
   logic [LANES-1:0]  x_be;
   logic [CMD_W-1:0]  pipe_d;
   logic [CMD_W-1:0]  pipe_q;
   logic [DW-1:0]     rd_data;

   assign en = ~clk_en_n;

   zbt_ctrl #(
      .ADDR_W     (ADDR_W),
      .LANES      (LANES),
      .BURST_BITS (BURST_BITS)
   ) u_ctrl (
      .clk         (clk),
      .rst         (rst),
      .en          (en),
      .sel0_n      (sel0_n),
      .sel1        (sel1),
      .sel2_n      (sel2_n),
      .burst_nload (burst_nload),
      .rd_nwr      (rd_nwr),
      .lane_we_n   (lane_we_n),
      .addr        (addr),
      .cmd_op      (c_op),
      .cmd_addr    (c_addr),
      .cmd_be      (c_be)
   );

   assign pipe_d = {c_addr, c_be, c_op};

   zbt_pipe #(
      .W      (CMD_W),
      .STAGES (PIPE_STAGES)
   ) u_pipe (
      .clk (clk),
      .rst (rst),
      .en  (en),
      .d   (pipe_d),
      .q   (pipe_q)
   );

   assign x_op   = op_e'(pipe_q[1:0]);
   assign x_be   = pipe_q[LANES+1:2];
   assign x_addr = pipe_q[CMD_W-1:LANES+2];

   zbt_store #(
      .ADDR_W (ADDR_W),
      .LANE_W (LANE_W),
      .LANES  (LANES)
   ) u_store (
      .clk    (clk),
      .rst    (rst),
      .en     (en),
      .op     (x_op),
      .addr   (x_addr),
      .be     (x_be),
      .wdata  (dq_in),
      .rdata  (rd_data),
      .rvalid (rd_valid)
   );

   assign dq_oe  = rd_valid & ~drv_en_n;
   assign dq_out = dq_oe ? rd_data : '0;

   // Checking support: edges seen since reset, saturating at three
   logic [1:0] age_q;
   logic       cmd_desel;
   logic       cmd_rd;
   logic       cmd_wr;

   always_ff @(posedge clk) begin
      if (rst)               age_q <= '0;
      else if (age_q != 2'd3) age_q <= age_q + 2'd1;
   end

   assign cmd_desel = en & ~burst_nload & (sel0_n | ~sel1 | sel2_n);
   assign cmd_rd    = en & ~burst_nload & ~sel0_n & sel1 & ~sel2_n & rd_nwr;
   assign cmd_wr    = en & ~burst_nload & ~sel0_n & sel1 & ~sel2_n & ~rd_nwr;

   // R2: deselect followed by two enabled edges gives no read data
   p_deselect_quiet_r2 : assert property (@(posedge clk) disable iff (rst)
      (age_q == 2'd3 && $past(cmd_desel, 3) && $past(en, 2) && $past(en, 1))
      |-> !rd_valid);

   // R3: read load followed by two enabled edges presents read data
   p_read_lat_r3 : assert property (@(posedge clk) disable iff (rst)
      (age_q == 2'd3 && $past(cmd_rd, 3) && $past(en, 2) && $past(en, 1))
      |-> rd_valid);

   // R4: write load never raises the read flag
   p_write_quiet_r4 : assert property (@(posedge clk) disable iff (rst)
      (age_q == 2'd3 && $past(cmd_wr, 3) && $past(en, 2) && $past(en, 1))
      |-> !rd_valid);

   // R8: a stalled edge leaves the read result untouched
   p_stall_hold_r8 : assert property (@(posedge clk) disable iff (rst)
      clk_en_n |=> ($stable(rd_valid) && $stable(rd_data)));

endmodule

// File: tb/zbt_sram_test.sv
module zbt_sram_test;

   localparam int CLK_PERIOD = 10;
   localparam int AW    = 5;
   localparam int LW    = 9;
   localparam int NL    = 2;
   localparam int DW    = LW * NL;
   localparam int DEPTH = 1 << AW;
   localparam int OPN   = 0;
   localparam int OPR   = 1;
   localparam int OPW   = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          clk_en_n = 1'b0;
   logic          sel0_n = 1'b1;
   logic          sel1 = 1'b0;
   logic          sel2_n = 1'b1;
   logic          burst_nload = 1'b0;
   logic          rd_nwr = 1'b1;
   logic [NL-1:0] lane_we_n = '1;
   logic          drv_en_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] dq_in = '0;
   logic [DW-1:0] dq_out;
   logic          dq_oe;
   logic          rd_valid;

   always #(CLK_PERIOD/2) clk = ~clk;

   zbt_sram #(
      .ADDR_W (AW),
      .LANE_W (LW),
      .LANES  (NL)
   ) uut (
      .clk         (clk),
      .rst         (rst),
      .clk_en_n    (clk_en_n),
      .sel0_n      (sel0_n),
      .sel1        (sel1),
      .sel2_n      (sel2_n),
      .burst_nload (burst_nload),
      .rd_nwr      (rd_nwr),
      .lane_we_n   (lane_we_n),
      .drv_en_n    (drv_en_n),
      .addr        (addr),
      .dq_in       (dq_in),
      .dq_out      (dq_out),
      .dq_oe       (dq_oe),
      .rd_valid    (rd_valid)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   // Reference state computed from the requirements
   logic [DW-1:0] mm [DEPTH];
   int            m_op = OPN, m_base = 0, m_cnt = 0;
   int            p1_op = OPN, p1_addr = 0, p2_op = OPN, p2_addr = 0;
   logic [NL-1:0] p1_be = '1, p2_be = '1;
   string         p1_tag = "R1", p2_tag = "R1";
   logic          exp_valid = 1'b0;
   logic [DW-1:0] exp_data = '0;

   function automatic logic [DW-1:0] wdata_of(int a, int s);
      return DW'(a * 2749 + s * 977 + 123);
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   // One clock: drive at the falling edge, model the rising edge, sample after it
   task automatic step(input logic hold, input logic s0n, input logic s1v,
                       input logic s2n, input logic brst, input logic rd,
                       input logic [NL-1:0] wen, input logic oen,
                       input int a, input string tag);
      int            op_n;
      int            ea;
      string         ctag;
      logic [DW-1:0] din;
      cyc++;
      din = (p2_op == OPW) ? wdata_of(p2_addr, cyc) : ~wdata_of(cyc, 7);
      clk_en_n = hold; sel0_n = s0n; sel1 = s1v; sel2_n = s2n;
      burst_nload = brst; rd_nwr = rd; lane_we_n = wen; drv_en_n = oen;
      addr = AW'(a); dq_in = din;
      if (!hold) begin
         if (!brst) begin
            op_n = (!s0n && s1v && !s2n) ? (rd ? OPR : OPW) : OPN;
            m_op = op_n; m_base = a; m_cnt = 0; ea = a;
         end else begin
            m_cnt = (m_cnt + 1) % 4;
            ea    = (m_base & ~3) | ((m_base + m_cnt) & 3);
            op_n  = m_op;
         end
         if (p2_op == OPW)
            for (int l = 0; l < NL; l++)
               if (!p2_be[l]) mm[p2_addr][l*LW +: LW] = din[l*LW +: LW];
         exp_valid = (p2_op == OPR);
         if (exp_valid) exp_data = mm[p2_addr];
         ctag = p2_tag;
         p2_op = p1_op; p2_addr = p1_addr; p2_be = p1_be; p2_tag = p1_tag;
         p1_op = op_n;  p1_addr = ea;      p1_be = wen;   p1_tag = tag;
      end else begin
         ctag = "R8";
      end
      if (oen) ctag = "R9";
      @(posedge clk);
      #(CLK_PERIOD/4);
      chk(ctag, "rd_valid", DW'(rd_valid), DW'(exp_valid));
      chk(ctag, "dq_oe", DW'(dq_oe), DW'(exp_valid && !oen));
      chk(ctag, "dq_out", dq_out, (exp_valid && !oen) ? exp_data : '0);
      @(negedge clk);
   endtask

   task automatic ld_rd(input int a, input string tag);
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '1, 1'b0, a, tag);
   endtask
   task automatic ld_wr(input int a, input logic [NL-1:0] wen, input string tag);
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, wen, 1'b0, a, tag);
   endtask
   task automatic burst(input string tag);
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, '0, 1'b0, 0, tag);
   endtask
   task automatic desel(input string tag);
      step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0, 0, tag);
   endtask

   // Starts and ends at a falling edge
   task automatic do_reset;
      rst = 1'b1; clk_en_n = 1'b0; burst_nload = 1'b0; sel0_n = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      p1_op = OPN; p2_op = OPN; exp_valid = 1'b0; exp_data = '0;
      m_op = OPN; m_cnt = 0; m_base = 0;
      chk("R1", "rd_valid after reset", DW'(rd_valid), '0);
      chk("R1", "dq_oe after reset", DW'(dq_oe), '0);
      chk("R1", "dq_out after reset", dq_out, '0);
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) mm[i] = '0;
      @(negedge clk);
      do_reset;

      // R1, R7: bursts straight after reset follow the cleared "none" direction
      for (int i = 0; i < 3; i++) burst("R7");

      // R4, R6: fill the whole array with four-word write bursts
      for (int b = 0; b < DEPTH; b += 4) begin
         ld_wr(b, '0, "R4");
         for (int i = 0; i < 3; i++) burst("R6");
      end
      desel("R2");
      desel("R2");

      // R3, R6: read everything back with bursts
      for (int b = 0; b < DEPTH; b += 4) begin
         ld_rd(b, "R3");
         for (int i = 0; i < 3; i++) burst("R6");
      end

      // R11: wrap inside the group from a mid-group start, then restart on a load
      ld_rd(6, "R11");
      for (int i = 0; i < 6; i++) burst("R11");
      ld_rd(13, "R11");
      burst("R11");

      // R2, R7: every non-selecting combination, each as a write attempt plus bursts
      for (int c = 0; c < 8; c++) begin
         logic [2:0] cb;
         cb = 3'(c);
         if (cb != 3'b010) begin
            step(1'b0, cb[2], cb[1], cb[0], 1'b0, 1'b0, '0, 1'b0, c, "R2");
            burst("R7");
            burst("R7");
         end
      end
      desel("R2");
      desel("R2");
      for (int c = 0; c < 8; c++) ld_rd(c, "R2");

      // R5, R10: all strobe patterns, each write read back on the next cycle
      for (int m = 0; m < 4; m++)
         for (int a = 8; a < 12; a++) begin
            ld_wr(a, NL'(m), "R5");
            ld_rd(a, "R10");
         end

      // R10: read and write interleaved every cycle
      for (int i = 0; i < 16; i++) begin
         ld_wr(16 + i, '0, "R10");
         ld_rd(16 + ((i + 5) % 16), "R10");
      end

      // R8: stalls with a conflicting write inside a read burst
      ld_rd(20, "R3");
      burst("R6");
      for (int i = 0; i < 3; i++)
         step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0, 3, "R8");
      burst("R6");
      burst("R6");
      for (int i = 0; i < 2; i++)
         step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0, 3, "R8");
      desel("R8");
      desel("R8");
      ld_rd(3, "R8");
      desel("R8");
      desel("R8");

      // R9: drive disabled during reads and during a write
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '1, 1'b1, 4, "R9");
      for (int i = 0; i < 3; i++)
         step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, '0, 1'b1, 0, "R9");
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 9, "R9");
      desel("R9");
      desel("R9");
      ld_rd(9, "R9");
      desel("R9");
      desel("R9");

      // R1: reset with a read in flight discards it
      ld_rd(5, "R1");
      do_reset;
      for (int i = 0; i < 3; i++) burst("R1");

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule